// File: doc/BRIEF.md
# Transmit Buffer Enqueue Scheduler

This block sits between software and the transmit engine of a cell-based network interface. Software fills a packet buffer and writes its header, which holds a write-failure flag, the target channel, the data length and the start offset. It then pushes the buffer number into the block through a valid/ready request port. The block handles one buffer at a time.

For each buffer the block first reads the header. If the data write that filled the buffer failed, the block raises a software event that carries the buffer number and does nothing else with that buffer. Otherwise it reads the channel descriptor named in the header.

If that channel is already transmitting, the buffer is linked to the tail of the channel's pending list. The list is first-in first-out: each header has a next pointer, and the descriptor holds head and tail pointers. If the channel is idle, the descriptor takes the length and offset from the header and becomes busy. The channel is then inserted into the time-wheel slot after the current one.

Packet memory, the descriptor table and the time wheel are modelled as internal arrays. Combinational look-up ports let the downstream engine read them. A configuration port loads each channel's scheduling parameters: peak rate, mean rate and adaptation type.

Top module: `txq_enqueue_sched`

## Requirements
- R1: `req_ready` is high only while no buffer is in process. After a request is accepted, `req_ready` is low until that buffer is fully handled.
- R2: A buffer whose header failure flag is 1 produces exactly one event with `evt_code` = 2'b01 and `evt_buf` = the buffer number. The target channel's descriptor and every time-wheel slot stay unchanged.
- R3: While `evt_valid` is high and `evt_ready` is low, the event stays valid with the same buffer number, and no new request is accepted.
- R4: A buffer for an idle channel leaves that channel busy, with head and tail pointers both equal to the buffer number, and with length and offset copied from the header.
- R5: The idle channel is inserted at the front of the list of slot (slot_now + 1) mod 2^SLOT_W. That slot then reports valid with head = the channel. The slot's previous head, and its valid bit, move to the channel's wheel link.
- R6: A buffer for a busy channel sets the old tail buffer's next pointer and the channel tail to the new buffer. The head pointer, the length, the offset and all slots stay unchanged.
- R7: `slot_now` advances by one on each cycle with `wheel_step` high, wraps from 2^SLOT_W-1 to 0, and holds otherwise.
- R8: A configuration write stores peak rate, mean rate and adaptation type for a channel, readable on the look-up port. It does not change that channel's busy state.
- R9: After reset, `req_ready` = 1, `evt_valid` = 0, `slot_now` = 0, every channel is idle and every slot is empty.
- R10: A channel becomes busy only through a buffer that was not marked failed. Once busy, it stays busy until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hdr_wr_en | input | 1 | Write one packet header |
| hdr_wr_buf | input | BUF_W | Buffer number of the header written |
| hdr_wr_fail | input | 1 | Data-write failure flag |
| hdr_wr_chan | input | CH_W | Target channel |
| hdr_wr_len | input | LEN_W | Data length |
| hdr_wr_off | input | OFF_W | Start offset |
| cfg_wr_en | input | 1 | Write channel scheduling parameters |
| cfg_wr_chan | input | CH_W | Channel configured |
| cfg_wr_peak | input | RATE_W | Peak rate |
| cfg_wr_mean | input | RATE_W | Mean rate |
| cfg_wr_aal | input | 2 | Adaptation type |
| req_valid | input | 1 | Buffer request valid |
| req_ready | output | 1 | Block can accept a buffer |
| req_buf | input | BUF_W | Buffer number to transmit |
| evt_valid | output | 1 | Software event valid |
| evt_ready | input | 1 | Software takes the event |
| evt_code | output | 2 | Event code (2'b01 = write failed) |
| evt_buf | output | BUF_W | Buffer number of the event |
| wheel_step | input | 1 | Advance the time wheel by one slot |
| slot_now | output | SLOT_W | Current time-wheel slot |
| look_chan | input | CH_W | Channel read on the look-up port |
| look_busy | output | 1 | Channel busy |
| look_head | output | BUF_W | First pending buffer |
| look_tail | output | BUF_W | Last pending buffer |
| look_len | output | LEN_W | Descriptor length |
| look_off | output | OFF_W | Descriptor offset |
| look_peak | output | RATE_W | Peak rate |
| look_mean | output | RATE_W | Mean rate |
| look_aal | output | 2 | Adaptation type |
| look_wnext | output | CH_W | Next channel in the same slot |
| look_wnext_vld | output | 1 | Wheel link valid |
| look_slot | input | SLOT_W | Slot read on the look-up port |
| look_slot_vld | output | 1 | Slot holds a channel |
| look_slot_head | output | CH_W | First channel in the slot |
| look_buf | input | BUF_W | Buffer read for its next pointer |
| look_buf_next | output | BUF_W | Next buffer in the channel list |

## Verification
The assertions assume that software never drops or changes `evt_buf` handling mid-event. They also assume that `req_buf` names a buffer whose header was written before the request. The busy-state properties assume that reset is held for at least two clock edges.

The bench writes every header before pushing its buffer, and it holds reset for several cycles. It keeps `wheel_step` and header writes quiet while a buffer is in process, so each expected slot follows from its own count of steps.

// File: rtl/txq_pkg.sv
// Shared types for the transmit buffer enqueue scheduler.
// Assumes: nothing beyond the parameters of the top module.
package txq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_DESC,
        ST_LINK,
        ST_SCHED,
        ST_EVT
    } txq_state_e;

    localparam logic [1:0] EVT_WRITE_FAIL = 2'b01;

endpackage

// File: rtl/txq_hdr_mem.sv
// Packet header store: the fields written by the filling path, plus a
// separate next-pointer array written only by the scheduler when it links
// buffers. Assumes the two writers never target the same field array.
module txq_hdr_mem #(
    parameter int BUF_W = 5,
    parameter int CH_W  = 3,
    parameter int LEN_W = 12,
    parameter int OFF_W = 6
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [BUF_W-1:0] wr_buf,
    input  logic             wr_fail,
    input  logic [CH_W-1:0]  wr_chan,
    input  logic [LEN_W-1:0] wr_len,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [BUF_W-1:0] rd_buf,
    output logic             rd_fail,
    output logic [CH_W-1:0]  rd_chan,
    output logic [LEN_W-1:0] rd_len,
    output logic [OFF_W-1:0] rd_off,
    input  logic             lnk_we,
    input  logic [BUF_W-1:0] lnk_buf,
    input  logic [BUF_W-1:0] lnk_next,
    input  logic [BUF_W-1:0] look_buf,
    output logic [BUF_W-1:0] look_next
);
    localparam int NBUF = 1 << BUF_W;

    logic             fail_m [NBUF];
    logic [CH_W-1:0]  chan_m [NBUF];
    logic [LEN_W-1:0] len_m  [NBUF];
    logic [OFF_W-1:0] off_m  [NBUF];
    logic [BUF_W-1:0] next_m [NBUF];

    // Store header fields from the filling path.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            fail_m[wr_buf] <= wr_fail;
            chan_m[wr_buf] <= wr_chan;
            len_m[wr_buf]  <= wr_len;
            off_m[wr_buf]  <= wr_off;
        end
    end

    // Store next pointers when a buffer is linked behind another.
    always_ff @(posedge clk) begin
        if (lnk_we) begin
            next_m[lnk_buf] <= lnk_next;
        end
    end

    // Asynchronous read ports.
    always_comb begin
        rd_fail   = fail_m[rd_buf];
        rd_chan   = chan_m[rd_buf];
        rd_len    = len_m[rd_buf];
        rd_off    = off_m[rd_buf];
        look_next = next_m[look_buf];
    end

endmodule

// File: rtl/txq_chan_table.sv
// Channel descriptor table: busy state, pending list pointers, copied
// length/offset, wheel link and scheduling parameters.
// Assumes at most one of sched_en / link_en is high per cycle.
module txq_chan_table #(
    parameter int BUF_W  = 5,
    parameter int CH_W   = 3,
    parameter int LEN_W  = 12,
    parameter int OFF_W  = 6,
    parameter int RATE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic [CH_W-1:0]   cfg_chan,
    input  logic [RATE_W-1:0] cfg_peak,
    input  logic [RATE_W-1:0] cfg_mean,
    input  logic [1:0]        cfg_aal,
    input  logic [CH_W-1:0]   rd_chan,
    output logic              rd_busy,
    output logic [BUF_W-1:0]  rd_tail,
    input  logic              sched_en,
    input  logic              link_en,
    input  logic [CH_W-1:0]   upd_chan,
    input  logic [BUF_W-1:0]  upd_buf,
    input  logic [LEN_W-1:0]  upd_len,
    input  logic [OFF_W-1:0]  upd_off,
    input  logic [CH_W-1:0]   upd_wnext,
    input  logic              upd_wnext_vld,
    input  logic [CH_W-1:0]   look_chan,
    output logic              look_busy,
    output logic [BUF_W-1:0]  look_head,
    output logic [BUF_W-1:0]  look_tail,
    output logic [LEN_W-1:0]  look_len,
    output logic [OFF_W-1:0]  look_off,
    output logic [RATE_W-1:0] look_peak,
    output logic [RATE_W-1:0] look_mean,
    output logic [1:0]        look_aal,
    output logic [CH_W-1:0]   look_wnext,
    output logic              look_wnext_vld,
    output logic [(1<<CH_W)-1:0] busy_vec
);
    localparam int NCH = 1 << CH_W;

    logic [NCH-1:0]    busy_q;
    logic [NCH-1:0]    wvld_q;
    logic [BUF_W-1:0]  head_m  [NCH];
    logic [BUF_W-1:0]  tail_m  [NCH];
    logic [LEN_W-1:0]  len_m   [NCH];
    logic [OFF_W-1:0]  off_m   [NCH];
    logic [CH_W-1:0]   wnext_m [NCH];
    logic [RATE_W-1:0] peak_m  [NCH];
    logic [RATE_W-1:0] mean_m  [NCH];
    logic [1:0]        aal_m   [NCH];

    // Busy and wheel-link valid flags, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
            wvld_q <= '0;
        end else if (sched_en) begin
            busy_q[upd_chan] <= 1'b1;
            wvld_q[upd_chan] <= upd_wnext_vld;
        end
    end

    // Descriptor pointer and size fields written by the scheduler.
    always_ff @(posedge clk) begin
        if (sched_en) begin
            head_m[upd_chan]  <= upd_buf;
            tail_m[upd_chan]  <= upd_buf;
            len_m[upd_chan]   <= upd_len;
            off_m[upd_chan]   <= upd_off;
            wnext_m[upd_chan] <= upd_wnext;
        end else if (link_en) begin
            tail_m[upd_chan]  <= upd_buf;
        end
    end

    // Scheduling parameters written by configuration.
    always_ff @(posedge clk) begin
        if (cfg_en) begin
            peak_m[cfg_chan] <= cfg_peak;
            mean_m[cfg_chan] <= cfg_mean;
            aal_m[cfg_chan]  <= cfg_aal;
        end
    end

    // Asynchronous read ports for the scheduler and the look-up port.
    always_comb begin
        rd_busy        = busy_q[rd_chan];
        rd_tail        = tail_m[rd_chan];
        look_busy      = busy_q[look_chan];
        look_head      = head_m[look_chan];
        look_tail      = tail_m[look_chan];
        look_len       = len_m[look_chan];
        look_off       = off_m[look_chan];
        look_peak      = peak_m[look_chan];
        look_mean      = mean_m[look_chan];
        look_aal       = aal_m[look_chan];
        look_wnext     = wnext_m[look_chan];
        look_wnext_vld = wvld_q[look_chan];
        busy_vec       = busy_q;
    end

endmodule

// File: rtl/txq_time_wheel.sv
// Time wheel: a slot counter and one list head per slot. Insertion always
// goes to the slot after the current one, at the front of its list.
// Assumes the caller links the returned previous head into the channel.
module txq_time_wheel #(
    parameter int CH_W   = 3,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [SLOT_W-1:0] slot_now,
    input  logic              ins_en,
    input  logic [CH_W-1:0]   ins_chan,
    output logic [CH_W-1:0]   prev_head,
    output logic              prev_vld,
    input  logic [SLOT_W-1:0] look_slot,
    output logic              look_vld,
    output logic [CH_W-1:0]   look_head
);
    localparam int NSLOT = 1 << SLOT_W;

    logic [SLOT_W-1:0] slot_q;
    logic [SLOT_W-1:0] ins_slot;
    logic [NSLOT-1:0]  vld_q;
    logic [CH_W-1:0]   head_m [NSLOT];

    // Target slot is one past the current slot, wrapping by width.
    assign ins_slot = slot_q + 1'b1;

    // Free-running slot counter advanced by step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else if (step) begin
            slot_q <= slot_q + 1'b1;
        end
    end

    // Slot occupancy flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (ins_en) begin
            vld_q[ins_slot] <= 1'b1;
        end
    end

    // Slot list heads.
    always_ff @(posedge clk) begin
        if (ins_en) begin
            head_m[ins_slot] <= ins_chan;
        end
    end

    // Read ports.
    always_comb begin
        slot_now  = slot_q;
        prev_head = head_m[ins_slot];
        prev_vld  = vld_q[ins_slot];
        look_vld  = vld_q[look_slot];
        look_head = head_m[look_slot];
    end

endmodule

// File: rtl/txq_ctrl.sv
// Per-buffer sequencer: accept, read header, test failure, read descriptor,
// then link, schedule or raise an event. Assumes asynchronous memory reads
// and that only one buffer is in process at a time.
module txq_ctrl
    import txq_pkg::*;
#(
    parameter int BUF_W = 5,
    parameter int CH_W  = 3,
    parameter int LEN_W = 12,
    parameter int OFF_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [BUF_W-1:0] req_buf,
    output logic             evt_valid,
    input  logic             evt_ready,
    output logic [1:0]       evt_code,
    output logic [BUF_W-1:0] evt_buf,
    output logic [BUF_W-1:0] hdr_rd_buf,
    input  logic             hdr_fail,
    input  logic [CH_W-1:0]  hdr_chan,
    input  logic [LEN_W-1:0] hdr_len,
    input  logic [OFF_W-1:0] hdr_off,
    output logic [CH_W-1:0]  desc_rd_chan,
    input  logic             desc_busy,
    input  logic [BUF_W-1:0] desc_tail,
    output logic             lnk_we,
    output logic [BUF_W-1:0] lnk_buf,
    output logic [BUF_W-1:0] lnk_next,
    output logic             sched_en,
    output logic             link_en,
    output logic [CH_W-1:0]  upd_chan,
    output logic [BUF_W-1:0] upd_buf,
    output logic [LEN_W-1:0] upd_len,
    output logic [OFF_W-1:0] upd_off
);
    txq_state_e       state_q;
    logic [BUF_W-1:0] buf_q;
    logic [CH_W-1:0]  chan_q;
    logic [LEN_W-1:0] len_q;
    logic [OFF_W-1:0] off_q;
    logic [BUF_W-1:0] tail_q;

    // State sequencing for one buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (req_valid) state_q <= ST_HDR;
                ST_HDR:   state_q <= hdr_fail ? ST_EVT : ST_DESC;
                ST_DESC:  state_q <= desc_busy ? ST_LINK : ST_SCHED;
                ST_LINK:  state_q <= ST_IDLE;
                ST_SCHED: state_q <= ST_IDLE;
                ST_EVT:   if (evt_ready) state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture the buffer number, header fields and descriptor tail.
    always_ff @(posedge clk) begin
        if (state_q == ST_IDLE && req_valid) begin
            buf_q <= req_buf;
        end
        if (state_q == ST_HDR) begin
            chan_q <= hdr_chan;
            len_q  <= hdr_len;
            off_q  <= hdr_off;
        end
        if (state_q == ST_DESC) begin
            tail_q <= desc_tail;
        end
    end

    // Handshake, memory addressing and update strobes.
    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        evt_valid    = (state_q == ST_EVT);
        evt_code     = EVT_WRITE_FAIL;
        evt_buf      = buf_q;
        hdr_rd_buf   = buf_q;
        desc_rd_chan = chan_q;
        lnk_we       = (state_q == ST_LINK);
        lnk_buf      = tail_q;
        lnk_next     = buf_q;
        link_en      = (state_q == ST_LINK);
        sched_en     = (state_q == ST_SCHED);
        upd_chan     = chan_q;
        upd_buf      = buf_q;
        upd_len      = len_q;
        upd_off      = off_q;
    end

endmodule

// File: rtl/txq_enqueue_sched.sv
// Top of the transmit buffer enqueue scheduler: joins the sequencer with
// the header store, descriptor table and time wheel.
// Assumes headers are written before their buffer is requested.
module txq_enqueue_sched #(
    parameter int BUF_W  = 5,
    parameter int CH_W   = 3,
    parameter int LEN_W  = 12,
    parameter int OFF_W  = 6,
    parameter int RATE_W = 10,
    parameter int SLOT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_wr_en,
    input  logic [BUF_W-1:0]  hdr_wr_buf,
    input  logic              hdr_wr_fail,
    input  logic [CH_W-1:0]   hdr_wr_chan,
    input  logic [LEN_W-1:0]  hdr_wr_len,
    input  logic [OFF_W-1:0]  hdr_wr_off,
    input  logic              cfg_wr_en,
    input  logic [CH_W-1:0]   cfg_wr_chan,
    input  logic [RATE_W-1:0] cfg_wr_peak,
    input  logic [RATE_W-1:0] cfg_wr_mean,
    input  logic [1:0]        cfg_wr_aal,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BUF_W-1:0]  req_buf,
    output logic              evt_valid,
    input  logic              evt_ready,
    output logic [1:0]        evt_code,
    output logic [BUF_W-1:0]  evt_buf,
    input  logic              wheel_step,
    output logic [SLOT_W-1:0] slot_now,
    input  logic [CH_W-1:0]   look_chan,
    output logic              look_busy,
    output logic [BUF_W-1:0]  look_head,
    output logic [BUF_W-1:0]  look_tail,
    output logic [LEN_W-1:0]  look_len,
    output logic [OFF_W-1:0]  look_off,
    output logic [RATE_W-1:0] look_peak,
    output logic [RATE_W-1:0] look_mean,
    output logic [1:0]        look_aal,
    output logic [CH_W-1:0]   look_wnext,
    output logic              look_wnext_vld,
    input  logic [SLOT_W-1:0] look_slot,
    output logic              look_slot_vld,
    output logic [CH_W-1:0]   look_slot_head,
    input  logic [BUF_W-1:0]  look_buf,
    output logic [BUF_W-1:0]  look_buf_next
);
    localparam int NCH = 1 << CH_W;

    logic [BUF_W-1:0] hdr_rd_buf;
    logic             hdr_fail;
    logic [CH_W-1:0]  hdr_chan;
    logic [LEN_W-1:0] hdr_len;
    logic [OFF_W-1:0] hdr_off;
    logic [CH_W-1:0]  desc_rd_chan;
    logic             desc_busy;
    logic [BUF_W-1:0] desc_tail;
    logic             lnk_we;
    logic [BUF_W-1:0] lnk_buf;
    logic [BUF_W-1:0] lnk_next;
    logic             sched_en;
    logic             link_en;
    logic [CH_W-1:0]  upd_chan;
    logic [BUF_W-1:0] upd_buf;
    logic [LEN_W-1:0] upd_len;
    logic [OFF_W-1:0] upd_off;
    logic [CH_W-1:0]  prev_head;
    logic             prev_vld;
    logic [NCH-1:0]   busy_vec;

    txq_ctrl #(.BUF_W(BUF_W), .CH_W(CH_W), .LEN_W(LEN_W), .OFF_W(OFF_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_buf(req_buf),
        .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_code(evt_code), .evt_buf(evt_buf),
        .hdr_rd_buf(hdr_rd_buf), .hdr_fail(hdr_fail), .hdr_chan(hdr_chan),
        .hdr_len(hdr_len), .hdr_off(hdr_off),
        .desc_rd_chan(desc_rd_chan), .desc_busy(desc_busy), .desc_tail(desc_tail),
        .lnk_we(lnk_we), .lnk_buf(lnk_buf), .lnk_next(lnk_next),
        .sched_en(sched_en), .link_en(link_en), .upd_chan(upd_chan),
        .upd_buf(upd_buf), .upd_len(upd_len), .upd_off(upd_off)
    );

    txq_hdr_mem #(.BUF_W(BUF_W), .CH_W(CH_W), .LEN_W(LEN_W), .OFF_W(OFF_W)) hdr_i (
        .clk(clk),
        .wr_en(hdr_wr_en), .wr_buf(hdr_wr_buf), .wr_fail(hdr_wr_fail),
        .wr_chan(hdr_wr_chan), .wr_len(hdr_wr_len), .wr_off(hdr_wr_off),
        .rd_buf(hdr_rd_buf), .rd_fail(hdr_fail), .rd_chan(hdr_chan),
        .rd_len(hdr_len), .rd_off(hdr_off),
        .lnk_we(lnk_we), .lnk_buf(lnk_buf), .lnk_next(lnk_next),
        .look_buf(look_buf), .look_next(look_buf_next)
    );

    txq_chan_table #(.BUF_W(BUF_W), .CH_W(CH_W), .LEN_W(LEN_W), .OFF_W(OFF_W),
                     .RATE_W(RATE_W)) chan_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_en(cfg_wr_en), .cfg_chan(cfg_wr_chan), .cfg_peak(cfg_wr_peak),
        .cfg_mean(cfg_wr_mean), .cfg_aal(cfg_wr_aal),
        .rd_chan(desc_rd_chan), .rd_busy(desc_busy), .rd_tail(desc_tail),
        .sched_en(sched_en), .link_en(link_en), .upd_chan(upd_chan),
        .upd_buf(upd_buf), .upd_len(upd_len), .upd_off(upd_off),
        .upd_wnext(prev_head), .upd_wnext_vld(prev_vld),
        .look_chan(look_chan), .look_busy(look_busy), .look_head(look_head),
        .look_tail(look_tail), .look_len(look_len), .look_off(look_off),
        .look_peak(look_peak), .look_mean(look_mean), .look_aal(look_aal),
        .look_wnext(look_wnext), .look_wnext_vld(look_wnext_vld),
        .busy_vec(busy_vec)
    );

    txq_time_wheel #(.CH_W(CH_W), .SLOT_W(SLOT_W)) wheel_i (
        .clk(clk), .rst_n(rst_n),
        .step(wheel_step), .slot_now(slot_now),
        .ins_en(sched_en), .ins_chan(upd_chan),
        .prev_head(prev_head), .prev_vld(prev_vld),
        .look_slot(look_slot), .look_vld(look_slot_vld), .look_head(look_slot_head)
    );

endmodule

// File: rtl/txq_enqueue_sched_chk.sv
// Property checker for the transmit buffer enqueue scheduler, bound to the
// top. Assumes reset is held for at least two clock edges.
module txq_enqueue_sched_chk #(
    parameter int BUF_W  = 5,
    parameter int CH_W   = 3,
    parameter int SLOT_W = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 evt_valid,
    input logic                 evt_ready,
    input logic [1:0]           evt_code,
    input logic [BUF_W-1:0]     evt_buf,
    input logic                 wheel_step,
    input logic [SLOT_W-1:0]    slot_now,
    input logic [(1<<CH_W)-1:0] busy_vec
);
    logic armed;

    // Enable history-based checks one cycle after reset ends.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    a_r1_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r1_ready_not_with_event: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && evt_valid));

    a_r2_event_code: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (evt_code == 2'b01));

    a_r3_event_held: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_buf)));

    a_r7_slot_step: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        wheel_step |=> (slot_now == $past(slot_now) + 1'b1));

    a_r7_slot_hold: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !wheel_step |=> $stable(slot_now));

    a_r10_busy_sticky: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (($past(busy_vec) & ~busy_vec) == '0));

    a_r10_one_new_busy: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($countones(busy_vec & ~$past(busy_vec)) <= 1));

endmodule

bind txq_enqueue_sched txq_enqueue_sched_chk #(
    .BUF_W(BUF_W), .CH_W(CH_W), .SLOT_W(SLOT_W)
) chk_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_code(evt_code), .evt_buf(evt_buf),
    .wheel_step(wheel_step), .slot_now(slot_now),
    .busy_vec(busy_vec)
);

// File: tb/txq_enqueue_sched_tb.sv
`timescale 1ns/1ps
module txq_enqueue_sched_tb_top;
    localparam int BUF_W = 5, CH_W = 3, LEN_W = 12, OFF_W = 6, RATE_W = 10, SLOT_W = 3;
    localparam int NCH = 1 << CH_W;
    localparam int NSLOT = 1 << SLOT_W;
    // Vector: {kind[1:0] (0 sched, 1 link, 2 event), buf[4:0], fail, chan[2:0]}
    localparam int NVEC = 8;
    localparam logic [10:0] VEC [NVEC] = '{
        {2'd0, 5'd3,  1'b0, 3'd2},
        {2'd1, 5'd5,  1'b0, 3'd2},
        {2'd2, 5'd7,  1'b1, 3'd2},
        {2'd1, 5'd9,  1'b0, 3'd2},
        {2'd0, 5'd10, 1'b0, 3'd4},
        {2'd1, 5'd11, 1'b0, 3'd4},
        {2'd2, 5'd12, 1'b1, 3'd4},
        {2'd0, 5'd14, 1'b0, 3'd0}
    };

    logic clk = 0, rst_n = 0;
    logic hdr_wr_en = 0, hdr_wr_fail = 0;
    logic [BUF_W-1:0] hdr_wr_buf = 0;
    logic [CH_W-1:0] hdr_wr_chan = 0;
    logic [LEN_W-1:0] hdr_wr_len = 0;
    logic [OFF_W-1:0] hdr_wr_off = 0;
    logic cfg_wr_en = 0;
    logic [CH_W-1:0] cfg_wr_chan = 0;
    logic [RATE_W-1:0] cfg_wr_peak = 0, cfg_wr_mean = 0;
    logic [1:0] cfg_wr_aal = 0;
    logic req_valid = 0, req_ready;
    logic [BUF_W-1:0] req_buf = 0;
    logic evt_valid, evt_ready = 1;
    logic [1:0] evt_code;
    logic [BUF_W-1:0] evt_buf;
    logic wheel_step = 0;
    logic [SLOT_W-1:0] slot_now;
    logic [CH_W-1:0] look_chan = 0;
    logic look_busy;
    logic [BUF_W-1:0] look_head, look_tail;
    logic [LEN_W-1:0] look_len;
    logic [OFF_W-1:0] look_off;
    logic [RATE_W-1:0] look_peak, look_mean;
    logic [1:0] look_aal;
    logic [CH_W-1:0] look_wnext;
    logic look_wnext_vld;
    logic [SLOT_W-1:0] look_slot = 0;
    logic look_slot_vld;
    logic [CH_W-1:0] look_slot_head;
    logic [BUF_W-1:0] look_buf = 0, look_buf_next;

    int checks = 0, errors = 0;
    bit done = 0;

    // Bench model state, built from the requirements.
    bit m_busy [NCH];
    int m_head [NCH], m_tail [NCH], m_len [NCH], m_off [NCH];
    bit m_svld [NSLOT];
    int m_shead [NSLOT];
    int m_slot;
    bit saw_evt;
    int evt_seen_buf, evt_seen_code;

    always #2 clk = ~clk;

    txq_enqueue_sched dut_i (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) m_busy[i] = 0;
        for (int i = 0; i < NSLOT; i++) m_svld[i] = 0;
        m_slot = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    task automatic write_hdr(input int b, input bit f, input int ch);
        @(negedge clk);
        hdr_wr_en = 1; hdr_wr_buf = BUF_W'(b); hdr_wr_fail = f;
        hdr_wr_chan = CH_W'(ch); hdr_wr_len = LEN_W'(b * 37 + 5); hdr_wr_off = OFF_W'(b + 1);
        @(negedge clk); hdr_wr_en = 0;
    endtask

    task automatic step_wheel(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); wheel_step = 1;
            @(negedge clk); wheel_step = 0;
            m_slot = (m_slot + 1) % NSLOT;
        end
    endtask

    // Push one buffer and wait until the block is ready again.
    task automatic push(input int b);
        int guard;
        @(negedge clk); req_valid = 1; req_buf = BUF_W'(b);
        @(negedge clk); req_valid = 0;
        saw_evt = 0; guard = 0;
        while (!req_ready && guard < 50) begin
            if (evt_valid) begin
                saw_evt = 1; evt_seen_buf = int'(evt_buf); evt_seen_code = int'(evt_code);
            end
            @(negedge clk); guard++;
        end
    endtask

    // Apply one buffer with its expected outcome and check the ports.
    task automatic run_buf(input int kind, input int b, input bit f, input int ch);
        int sl, prev_tail, prev_head, old_shead;
        bit old_svld;
        sl = (m_slot + 1) % NSLOT;
        prev_tail = m_tail[ch]; prev_head = m_head[ch];
        old_svld = m_svld[sl]; old_shead = m_shead[sl];
        write_hdr(b, f, ch);
        push(b);
        look_chan = CH_W'(ch); look_slot = SLOT_W'(sl); look_buf = BUF_W'(prev_tail);
        #0.5;
        if (kind == 2) begin
            chk(saw_evt && evt_seen_buf == b, "R2 event buffer", evt_seen_buf, b);
            chk(evt_seen_code == 1, "R2 event code", evt_seen_code, 1);
            chk(look_busy == m_busy[ch], "R2 busy untouched", look_busy, m_busy[ch]);
            chk(look_slot_vld == old_svld, "R2 slot untouched", look_slot_vld, old_svld);
            if (m_busy[ch]) chk(int'(look_tail) == prev_tail, "R2 tail untouched", look_tail, prev_tail);
        end else if (kind == 1) begin
            chk(!saw_evt, "R6 no event", saw_evt, 0);
            chk(int'(look_tail) == b, "R6 tail", look_tail, b);
            chk(int'(look_head) == prev_head, "R6 head kept", look_head, prev_head);
            chk(int'(look_buf_next) == b, "R6 old tail next", look_buf_next, b);
            chk(look_len == LEN_W'(m_len[ch]), "R6 length kept", look_len, m_len[ch]);
            chk(look_slot_vld == old_svld && (!old_svld || int'(look_slot_head) == old_shead),
                "R6 slot untouched", look_slot_head, old_shead);
            m_tail[ch] = b;
        end else begin
            chk(!saw_evt, "R4 no event", saw_evt, 0);
            chk(look_busy == 1'b1, "R4 busy set", look_busy, 1);
            chk(int'(look_head) == b && int'(look_tail) == b, "R4 head and tail", look_head, b);
            chk(look_len == LEN_W'(b * 37 + 5), "R4 length copied", look_len, b * 37 + 5);
            chk(look_off == OFF_W'(b + 1), "R4 offset copied", look_off, b + 1);
            chk(look_slot_vld && int'(look_slot_head) == ch, "R5 slot head", look_slot_head, ch);
            chk(look_wnext_vld == old_svld, "R5 link valid", look_wnext_vld, old_svld);
            if (old_svld) chk(int'(look_wnext) == old_shead, "R5 link to old head", look_wnext, old_shead);
            m_busy[ch] = 1; m_head[ch] = b; m_tail[ch] = b;
            m_len[ch] = b * 37 + 5; m_off[ch] = b + 1;
            m_svld[sl] = 1; m_shead[sl] = ch;
        end
    endtask

    initial begin
        do_reset();
        // R9 reset state
        #0.5;
        chk(req_ready == 1, "R9 ready", req_ready, 1);
        chk(evt_valid == 0, "R9 no event", evt_valid, 0);
        chk(slot_now == 0, "R9 slot zero", slot_now, 0);
        for (int i = 0; i < NCH; i++) begin
            look_chan = CH_W'(i); #0.1;
            chk(look_busy == 0, "R9 channel idle", look_busy, 0);
        end
        for (int i = 0; i < NSLOT; i++) begin
            look_slot = SLOT_W'(i); #0.1;
            chk(look_slot_vld == 0, "R9 slot empty", look_slot_vld, 0);
        end

        // Vector table: schedule, link and failure cases on shared channels.
        for (int i = 0; i < NVEC; i++) begin
            logic [10:0] v;
            v = VEC[i];
            run_buf(int'(v[10:9]), int'(v[8:4]), v[3], int'(v[2:0]));
        end

        // R1 ready low while a buffer is in process.
        write_hdr(20, 0, 6);
        @(negedge clk); req_valid = 1; req_buf = 5'd20;
        @(negedge clk); req_valid = 0;
        chk(req_ready == 0, "R1 busy after accept", req_ready, 0);
        @(negedge clk);
        chk(req_ready == 0, "R1 busy mid process", req_ready, 0);
        repeat (3) @(negedge clk);
        chk(req_ready == 1, "R1 ready after finish", req_ready, 1);
        m_busy[6] = 1; m_head[6] = 20; m_tail[6] = 20;
        m_svld[(m_slot + 1) % NSLOT] = 1; m_shead[(m_slot + 1) % NSLOT] = 6;

        // R3 event stall: no acceptance, stable buffer number.
        do_reset();
        evt_ready = 0;
        write_hdr(17, 1, 5);
        @(negedge clk); req_valid = 1; req_buf = 5'd17;
        @(negedge clk); req_buf = 5'd18;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            chk(evt_valid == 1, "R3 event held", evt_valid, 1);
            chk(int'(evt_buf) == 17, "R3 buffer stable", evt_buf, 17);
            chk(req_ready == 0, "R3 no accept while stalled", req_ready, 0);
            @(negedge clk);
        end
        req_valid = 0; evt_ready = 1;
        @(negedge clk);
        chk(evt_valid == 0, "R3 event taken", evt_valid, 1'b0);
        chk(req_ready == 1, "R3 ready after take", req_ready, 1);
        look_chan = 3'd5; #0.5;
        chk(look_busy == 0, "R2 failed buffer leaves idle channel idle", look_busy, 0);

        // R7 wheel stepping and wrap; R5 insertion follows the counter.
        step_wheel(3);
        #0.5;
        chk(int'(slot_now) == 3, "R7 slot after three steps", slot_now, 3);
        run_buf(0, 21, 0, 1);
        step_wheel(4);
        #0.5;
        chk(int'(slot_now) == 7, "R7 slot at top", slot_now, 7);
        run_buf(0, 22, 0, 3);
        look_slot = 3'd0; #0.5;
        chk(look_slot_vld && look_slot_head == 3'd3, "R5 insertion wraps to slot 0", look_slot_head, 3);
        step_wheel(1);
        #0.5;
        chk(int'(slot_now) == 0, "R7 slot wrap", slot_now, 0);

        // R8 configuration readback, busy state unchanged.
        @(negedge clk);
        cfg_wr_en = 1; cfg_wr_chan = 3'd3; cfg_wr_peak = 10'd700; cfg_wr_mean = 10'd250; cfg_wr_aal = 2'd2;
        @(negedge clk);
        cfg_wr_chan = 3'd6; cfg_wr_peak = 10'd99; cfg_wr_mean = 10'd44; cfg_wr_aal = 2'd1;
        @(negedge clk); cfg_wr_en = 0;
        look_chan = 3'd3; #0.5;
        chk(look_peak == 10'd700 && look_mean == 10'd250, "R8 rates stored", look_peak, 700);
        chk(look_aal == 2'd2, "R8 type stored", look_aal, 2);
        chk(look_busy == 1, "R8 busy kept on busy channel", look_busy, 1);
        look_chan = 3'd6; #0.5;
        chk(look_peak == 10'd99 && look_aal == 2'd1, "R8 second channel", look_peak, 99);
        chk(look_busy == 0, "R8 idle kept on idle channel", look_busy, 0);

        // R10 failed buffer on an idle channel, then a good one on the same channel.
        run_buf(2, 23, 1, 7);
        look_chan = 3'd7; #0.5;
        chk(look_busy == 0, "R10 no busy from failed buffer", look_busy, 0);
        run_buf(0, 24, 0, 7);
        run_buf(1, 25, 0, 7);

        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule